// File: doc/BRIEF.md
# Bidirectional Cascadable Row Scan Register

This block is the logic core of a display row driver. A chain of one-bit stages (64 by default) is loaded serially and presented in parallel to the row electrodes. Data moves on each rising edge of the shift clock, and a direction select decides which way it moves. The two serial pins swap roles with the direction: one takes data in, the other passes it on. Several devices can therefore be wired end to end to cover any number of rows. In reverse mode data enters on the far pin and leaves on the near one.

Between the stages and the rows sits a level-sensitive hold latch. It is transparent while the strobe is low and frozen while the strobe is high. The rows show the inverse of the latch contents, unless one of two controls overrides them. A low polarity control pulls every row low, and this override has the highest priority. A high blanking input, with polarity high, drives every row high. An active-high clear empties the chain at once, without waiting for a clock edge.

Top module: `row_scan_driver`

## Requirements
- R1: While the shift clock has no rising edge, the stage contents and the rows stay unchanged, whatever the serial inputs and the direction select do.
- R2: With fwd high, each rising edge loads pin A input (sa_in) into stage 1 (rows bit 0) and moves stage k into stage k+1.
- R3: With fwd low, each rising edge loads pin B input (sb_in) into the last stage (rows bit STAGES-1) and moves stage k+1 into stage k.
- R4: The serial output is the last stage (sb_out) going forward and stage 1 (sa_out) in reverse. A bit presented at the serial input appears at the serial output after exactly STAGES rising edges, and after 2*STAGES edges at the end of a two-device chain.
- R5: While clr is high, every stage reads 0 at once, with no clock edge needed, and shifting is blocked.
- R6: The hold latch follows the stages while strobe is low and keeps its value while strobe is high.
- R7: When pol is low, all rows are 0, regardless of blank, strobe and clr.
- R8: When pol is high and blank is high, all rows are 1.
- R9: When pol is high and blank is low, each row is the inverse of its latch bit. With strobe low and clr high, every row is therefore 1.
- R10: sb_oe equals fwd and sa_oe equals the inverse of fwd, so only the pin acting as serial output is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock, rising-edge active |
| clr | input | 1 | Asynchronous clear, active high |
| fwd | input | 1 | Direction: 1 forward, 0 reverse |
| strobe | input | 1 | Latch control: low transparent, high hold |
| pol | input | 1 | Polarity control; low forces all rows low |
| blank | input | 1 | Blanking; high forces rows high when pol is high |
| sa_in | input | 1 | Serial pin A input side |
| sa_out | output | 1 | Serial pin A output side (stage 1) |
| sa_oe | output | 1 | Serial pin A driver enable |
| sb_in | input | 1 | Serial pin B input side |
| sb_out | output | 1 | Serial pin B output side (last stage) |
| sb_oe | output | 1 | Serial pin B driver enable |
| rows | output | STAGES | Row output levels, bit 0 is stage 1 |

## Verification
Two pairs of functions can coincide. A clear can be raised while the strobe is low, and it must then reach the rows at once through the transparent latch. A shift edge can arrive while the strobe is high, and the rows must then stay frozen while the stages move underneath. The bench sets these overlaps by changing clr, strobe, pol and blank between clock edges, and it steps through all sixteen combinations of the four controls. It judges each moment by comparing both chained devices against a behavioural queue model: once a few ns after each input change, and once at every falling edge of the clock.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic {
        DIR_REV = 1'b0,
        DIR_FWD = 1'b1
    } scan_dir_e;

    typedef enum logic [1:0] {
        ROW_LOW  = 2'd0,
        ROW_HIGH = 2'd1,
        ROW_DATA = 2'd2
    } row_mode_e;

    // Polarity outranks blanking; only with both released does data show.
    function automatic row_mode_e pick_mode(input logic pol, input logic blank);
        if (!pol)
            return ROW_LOW;
        else if (blank)
            return ROW_HIGH;
        else
            return ROW_DATA;
    endfunction

endpackage

// File: rtl/scan_shift_core.sv
module scan_shift_core
    import scan_pkg::*;
#(
    parameter int STAGES = 64
) (
    input  logic              clk,
    input  logic              clr,
    input  scan_dir_e         dir,
    input  logic              head_in,
    input  logic              tail_in,
    output logic [STAGES-1:0] cells
);

    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] cells;
    } shift_state_t;

    shift_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (dir == DIR_FWD)
            state_d.cells = {state_q.cells[LAST-1:0], head_in};
        else
            state_d.cells = {tail_in, state_q.cells[LAST:1]};
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign cells = state_q.cells;

    // R2: forward entry point takes the head pin
    a_r2_fwd_entry: assert property (@(posedge clk) disable iff (clr)
        (dir == DIR_FWD) |=> (state_q.cells[0] == $past(head_in)));

    // R2: forward movement toward the last stage
    a_r2_fwd_move: assert property (@(posedge clk) disable iff (clr)
        (dir == DIR_FWD) |=> (state_q.cells[LAST] == $past(state_q.cells[LAST-1])));

    // R3: reverse entry point takes the tail pin
    a_r3_rev_entry: assert property (@(posedge clk) disable iff (clr)
        (dir == DIR_REV) |=> (state_q.cells[LAST] == $past(tail_in)));

    // R3: reverse movement toward stage 1
    a_r3_rev_move: assert property (@(posedge clk) disable iff (clr)
        (dir == DIR_REV) |=> (state_q.cells[0] == $past(state_q.cells[1])));

endmodule

// File: rtl/scan_hold_latch.sv
module scan_hold_latch #(
    parameter int STAGES = 64
) (
    input  logic              strobe,
    input  logic [STAGES-1:0] data_d,
    output logic [STAGES-1:0] held_q
);

    always_latch begin
        if (!strobe)
            held_q = data_d;
    end

endmodule

// File: rtl/scan_row_ctrl.sv
module scan_row_ctrl
    import scan_pkg::*;
#(
    parameter int STAGES = 64
) (
    input  logic              pol,
    input  logic              blank,
    input  logic [STAGES-1:0] held,
    output logic [STAGES-1:0] rows
);

    row_mode_e mode;

    always_comb mode = pick_mode(pol, blank);

    for (genvar g = 0; g < STAGES; g++) begin : g_row
        always_comb begin
            unique case (mode)
                ROW_HIGH: rows[g] = 1'b1;
                ROW_DATA: rows[g] = ~held[g];
                default:  rows[g] = 1'b0;
            endcase
        end
    end

    // R7: polarity low wins over everything
    always_comb begin
        if (!pol)
            a_r7_pol_low: assert (rows == '0);
    end

    // R8: blanking with polarity high drives every row high
    always_comb begin
        if (pol && blank)
            a_r8_blank_high: assert (&rows);
    end

endmodule

// File: rtl/row_scan_driver.sv
module row_scan_driver
    import scan_pkg::*;
#(
    parameter int STAGES = 64
) (
    input  logic              shift_clk,
    input  logic              clr,
    input  logic              fwd,
    input  logic              strobe,
    input  logic              pol,
    input  logic              blank,
    input  logic              sa_in,
    output logic              sa_out,
    output logic              sa_oe,
    input  logic              sb_in,
    output logic              sb_out,
    output logic              sb_oe,
    output logic [STAGES-1:0] rows
);

    localparam int LAST = STAGES - 1;

    scan_dir_e         dir;
    logic [STAGES-1:0] cells;
    logic [STAGES-1:0] held;

    always_comb dir = fwd ? DIR_FWD : DIR_REV;

    scan_shift_core #(.STAGES(STAGES)) i_core (
        .clk     (shift_clk),
        .clr     (clr),
        .dir     (dir),
        .head_in (sa_in),
        .tail_in (sb_in),
        .cells   (cells)
    );

    scan_hold_latch #(.STAGES(STAGES)) i_latch (
        .strobe (strobe),
        .data_d (cells),
        .held_q (held)
    );

    scan_row_ctrl #(.STAGES(STAGES)) i_rows (
        .pol   (pol),
        .blank (blank),
        .held  (held),
        .rows  (rows)
    );

    assign sa_out = cells[0];
    assign sb_out = cells[LAST];
    assign sa_oe  = (dir == DIR_REV);
    assign sb_oe  = (dir == DIR_FWD);

    // R6: latch contents frozen across edges while strobe stays high
    a_r6_latch_hold: assert property (@(posedge shift_clk) disable iff (clr)
        (strobe && $past(strobe)) |-> $stable(held));

    // R10: never both serial pins driven
    always_comb begin
        a_r10_one_driver: assert (!(sa_oe && sb_oe));
    end

endmodule

// File: tb/test_row_scan_driver.sv
module test_row_scan_driver;

    localparam int N = 64;

    logic clk = 1'b0;
    logic clk_en = 1'b1;
    logic clr = 1'b1;
    logic fwd = 1'b1;
    logic strobe = 1'b0;
    logic pol = 1'b1;
    logic blank = 1'b0;
    logic ext_a = 1'b0;
    logic ext_b = 1'b0;
    logic sclk;

    logic d0_sa_out, d0_sa_oe, d0_sb_out, d0_sb_oe;
    logic d1_sa_out, d1_sa_oe, d1_sb_out, d1_sb_oe;
    logic link;
    logic [N-1:0] r0, r1;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    bit chain[$];
    bit held[2*N];

    always #4 clk = ~clk;
    assign sclk = clk & clk_en;
    assign link = d0_sb_oe ? d0_sb_out : d1_sa_out;

    row_scan_driver #(.STAGES(N)) i_row_scan_driver (
        .shift_clk(sclk), .clr(clr), .fwd(fwd), .strobe(strobe),
        .pol(pol), .blank(blank),
        .sa_in(ext_a), .sa_out(d0_sa_out), .sa_oe(d0_sa_oe),
        .sb_in(link), .sb_out(d0_sb_out), .sb_oe(d0_sb_oe),
        .rows(r0)
    );

    row_scan_driver #(.STAGES(N)) i_row_scan_driver_b (
        .shift_clk(sclk), .clr(clr), .fwd(fwd), .strobe(strobe),
        .pol(pol), .blank(blank),
        .sa_in(link), .sa_out(d1_sa_out), .sa_oe(d1_sa_oe),
        .sb_in(ext_b), .sb_out(d1_sb_out), .sb_oe(d1_sb_oe),
        .rows(r1)
    );

    // Behavioural model: one queue spanning both devices, index 0 = device 0 stage 1
    always @(posedge clk) begin
        if (clk_en) begin
            if (clr) begin
                foreach (chain[i]) chain[i] = 0;
            end else if (fwd) begin
                chain.push_front(ext_a);
                void'(chain.pop_back());
            end else begin
                chain.push_back(ext_b);
                void'(chain.pop_front());
            end
        end
    end

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] want_rows(logic [N-1:0] lat);
        if (!pol) return '0;
        if (blank) return '1;
        return ~lat;
    endfunction

    task automatic compare(string tag);
        logic [N-1:0] l0, l1;
        if (clr) foreach (chain[i]) chain[i] = 0;
        if (!strobe) for (int i = 0; i < 2*N; i++) held[i] = chain[i];
        for (int i = 0; i < N; i++) begin
            l0[i] = held[i];
            l1[i] = held[N+i];
        end
        check(tag, r0, want_rows(l0));
        check(tag, r1, want_rows(l1));
        check("R4 serial", {N{1'b0}} | {d0_sa_out, d0_sb_out, d1_sa_out, d1_sb_out},
              {N{1'b0}} | {logic'(chain[0]), logic'(chain[N-1]), logic'(chain[N]), logic'(chain[2*N-1])});
        check("R10 enables", {N{1'b0}} | {d0_sa_oe, d0_sb_oe, d1_sa_oe, d1_sb_oe},
              {N{1'b0}} | {~fwd, fwd, ~fwd, fwd});
    endtask

    task automatic tick(string tag);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic latency(bit dir_fwd);
        int n;
        fwd = dir_fwd;
        clr = 1'b1;
        tick("R5 clear");
        clr = 1'b0;
        ext_a = dir_fwd;
        ext_b = !dir_fwd;
        n = 0;
        while (!(dir_fwd ? d0_sb_out : d1_sa_out) && n < 300) begin
            tick(dir_fwd ? "R2 latency" : "R3 latency");
            ext_a = 1'b0;
            ext_b = 1'b0;
            n++;
        end
        check("R4 one device", N'(n), N'(N));
        while (!(dir_fwd ? d1_sb_out : d0_sa_out) && n < 300) begin
            tick("R4 chain");
            n++;
        end
        check("R4 two devices", N'(n), N'(2*N));
    endtask

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < 2*N; i++) chain.push_back(0);
        lfsr = 16'hACE1;

        // R5: clear held from time zero, rows show inverted zeros
        repeat (3) tick("R5 reset");
        clr = 1'b0;

        // R2: forward random stream, strobe toggling
        for (int k = 0; k < 150; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ext_a = lfsr[0];
            strobe = (k % 7 == 3);
            tick("R2 forward");
        end
        strobe = 1'b0;

        // R3: reverse random stream
        fwd = 1'b0;
        for (int k = 0; k < 150; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ext_b = lfsr[0];
            tick("R3 reverse");
        end

        // R4: latency in both directions through the two-device chain
        latency(1'b1);
        latency(1'b0);

        // R1: no clock edges, inputs wiggle, nothing moves
        fwd = 1'b1;
        for (int k = 0; k < 40; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ext_a = lfsr[0];
            tick("R1 load");
        end
        clk_en = 1'b0;
        for (int k = 0; k < 10; k++) begin
            ext_a = k[0];
            ext_b = ~k[0];
            fwd = k[1];
            tick("R1 hold");
        end
        fwd = 1'b1;
        clk_en = 1'b1;

        // R6: strobe high freezes rows while stages keep shifting
        strobe = 1'b1;
        for (int k = 0; k < 20; k++) begin
            ext_a = k[1];
            tick("R6 hold");
        end
        strobe = 1'b0;
        #1 compare("R6 transparent");
        tick("R6 transparent");

        // R5: asynchronous clear seen at the rows before any edge
        strobe = 1'b0;
        clr = 1'b1;
        #1 compare("R5 async");
        tick("R5 async");
        clr = 1'b0;
        for (int k = 0; k < 8; k++) begin
            ext_a = 1'b1;
            tick("R2 refill");
        end

        // R7 R8 R9: every combination of pol, blank, strobe, clr
        for (int c = 0; c < 16; c++) begin
            pol = c[0];
            blank = c[1];
            strobe = c[2];
            clr = c[3];
            #1 compare(!pol ? "R7 pol low" : (blank ? "R8 blank" : "R9 data"));
            tick(!pol ? "R7 pol low" : (blank ? "R8 blank" : "R9 data"));
            clr = 1'b0;
            ext_a = c[0] ^ c[2];
            tick("R9 refill");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule